// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block generates the raster timing of a display: horizontal sync, vertical sync, a display-enable flag, a strobe on the last pixel of each line and a strobe on the last pixel of each frame. The horizontal and vertical position counters are 16-bit linear feedback shift registers, not binary counters. A shift register needs no carry chain, so the counter logic is only one XOR level deep at any width. Every timing event is an equality compare between a counter and a programmed shift-register state.

The programmed states are the states the register reaches after a given number of steps from the all-ones start value. Software, or a bench, that thinks in binary counts uses the built-in converter to turn a count into a state. It starts the converter with a one-cycle pulse, and the converter then steps a private copy of the register once per clock. The timing inputs are taken to be static while reset is released. To change them, reset the block.

Top module: `lfsr_raster_timing`

## Requirements
- R1: While reset is held, both position counters rest at 0xFFFF (count 0). The outputs then reflect count 0: with the usual programming, hsync is low, vsync is high and display enable is low.
- R2: Each clock, the horizontal counter moves from state s to {s[14:0], s[15]^s[4]^s[2]^s[1]}. In the cycle where it equals `h_last_st`, `line_stb` is high, and on the next clock the counter returns to 0xFFFF. A line therefore lasts N+1 clocks when `h_last_st` is the state reached after N steps.
- R3: The vertical counter takes one step only on a clock where `line_stb` is high, and holds its value otherwise. On the line where it equals `v_last_st`, it reloads 0xFFFF instead. `frame_stb` is high only on the last pixel of that line.
- R4: `hsync` is high from the cycle in which the horizontal counter matches `hs_beg_st`, inclusive. It stays high up to, but not including, the cycle in which the counter matches `hs_end_st`.
- R5: `vsync` follows the same start-inclusive, end-exclusive rule on the vertical counter, using `vs_beg_st` and `vs_end_st`.
- R6: `de` is high exactly when the horizontal count is inside [`ha_beg_st`, `ha_end_st`) and the vertical count is also inside [`va_beg_st`, `va_end_st`).
- R7: A `cv_go` pulse with `cv_count` = 0 gives `cv_done` high one clock later, with `cv_state` = 0xFFFF.
- R8: A `cv_go` pulse with `cv_count` = N > 0 keeps `cv_done` low while stepping. `cv_done` rises N+1 clocks after the pulse, with `cv_state` equal to the state after N steps from 0xFFFF. Done and state then hold until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| ha_beg_st | input | 16 | horizontal active start, as a register state |
| ha_end_st | input | 16 | horizontal active end (exclusive), as a state |
| h_last_st | input | 16 | state of the last pixel of a line |
| hs_beg_st | input | 16 | horizontal sync start state |
| hs_end_st | input | 16 | horizontal sync end state (exclusive) |
| va_beg_st | input | 16 | vertical active start state |
| va_end_st | input | 16 | vertical active end state (exclusive) |
| v_last_st | input | 16 | state of the last line of a frame |
| vs_beg_st | input | 16 | vertical sync start state |
| vs_end_st | input | 16 | vertical sync end state (exclusive) |
| cv_go | input | 1 | converter start pulse |
| cv_count | input | 16 | binary step count to convert |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | display enable |
| line_stb | output | 1 | last pixel of a line |
| frame_stb | output | 1 | last pixel of a frame |
| cv_done | output | 1 | converter result valid |
| cv_state | output | 16 | converted register state |

## Verification
The hardest case to reach is the wrap of both counters together. It only occurs on the final pixel of the final line, so the vertical window, the vertical reload and the frame strobe are all exercised once per frame at most. The bench uses two very small raster modes so that it can run several complete frames, including each vertical wrap. It computes the expected timing with its own binary counters and its own shift-register model, then compares every output on every cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hFFFF;

  // One shift step: left shift, feedback from bits 15, 4, 2, 1 into bit 0.
  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction
endpackage

// File: rtl/vtg_lfsr_ctr.sv
module vtg_lfsr_ctr
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [LFSR_W-1:0] last_st,
  output logic [LFSR_W-1:0] pos,
  output logic              at_last
);
  assign at_last = (pos == last_st);

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= LFSR_SEED;
    else if (adv)     pos <= at_last ? LFSR_SEED : lfsr_adv(pos);
  end

  AST_WRAP_TO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_last) |=> (pos == LFSR_SEED));                    // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos));                                       // R3
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pos != '0);                                                   // R2
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] pos,
  input  logic [LFSR_W-1:0] beg_st,
  input  logic [LFSR_W-1:0] end_st,
  output logic              active
);
  logic win_q;
  logic hit_beg, hit_end;

  assign hit_beg = (pos == beg_st);
  assign hit_end = (pos == end_st);
  assign active  = (win_q | hit_beg) & ~hit_end;

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= active;
  end
endmodule

// File: rtl/vtg_bin2lfsr.sv
module vtg_bin2lfsr
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LFSR_W-1:0] count,
  output logic              done,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= LFSR_SEED;
      remain <= '0;
      done   <= 1'b0;
    end else if (go) begin
      state  <= LFSR_SEED;
      remain <= count;
      done   <= (count == '0);
    end else if (remain != '0) begin
      state  <= lfsr_adv(state);
      remain <= remain - 1'b1;
      if (remain == 1) done <= 1'b1;
    end
  end

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count == '0) |=> (done && state == LFSR_SEED));       // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && $stable(state)));                 // R8
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count != '0) |=> !done);                              // R8
endmodule

// File: rtl/lfsr_raster_timing.sv
module lfsr_raster_timing
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       ha_beg_st,
  input  logic [15:0]       ha_end_st,
  input  logic [15:0]       h_last_st,
  input  logic [15:0]       hs_beg_st,
  input  logic [15:0]       hs_end_st,
  input  logic [15:0]       va_beg_st,
  input  logic [15:0]       va_end_st,
  input  logic [15:0]       v_last_st,
  input  logic [15:0]       vs_beg_st,
  input  logic [15:0]       vs_end_st,
  input  logic              cv_go,
  input  logic [15:0]       cv_count,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              line_stb,
  output logic              frame_stb,
  output logic              cv_done,
  output logic [15:0]       cv_state
);
  localparam int NWIN = 4; // 0 h-active, 1 h-sync, 2 v-active, 3 v-sync

  logic [LFSR_W-1:0] hpos, vpos;
  logic              h_end, v_end;
  logic [LFSR_W-1:0] w_beg [NWIN];
  logic [LFSR_W-1:0] w_end [NWIN];
  logic [NWIN-1:0]   w_act;

  vtg_lfsr_ctr u_hctr (
    .clk(clk), .rst_n(rst_n), .adv(1'b1),
    .last_st(h_last_st), .pos(hpos), .at_last(h_end));

  vtg_lfsr_ctr u_vctr (
    .clk(clk), .rst_n(rst_n), .adv(h_end),
    .last_st(v_last_st), .pos(vpos), .at_last(v_end));

  assign w_beg[0] = ha_beg_st;  assign w_end[0] = ha_end_st;
  assign w_beg[1] = hs_beg_st;  assign w_end[1] = hs_end_st;
  assign w_beg[2] = va_beg_st;  assign w_end[2] = va_end_st;
  assign w_beg[3] = vs_beg_st;  assign w_end[3] = vs_end_st;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    vtg_window u_win (
      .clk(clk), .rst_n(rst_n),
      .pos((i < 2) ? hpos : vpos),
      .beg_st(w_beg[i]), .end_st(w_end[i]),
      .active(w_act[i]));
  end

  assign de        = w_act[0] & w_act[2];
  assign hsync     = w_act[1];
  assign vsync     = w_act[3];
  assign line_stb  = h_end;
  assign frame_stb = h_end & v_end;

  vtg_bin2lfsr u_conv (
    .clk(clk), .rst_n(rst_n), .go(cv_go), .count(cv_count),
    .done(cv_done), .state(cv_state));

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (vpos == LFSR_SEED && hpos == LFSR_SEED));     // R3
endmodule

// File: tb/lfsr_raster_timing_test.sv
module lfsr_raster_timing_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ha_beg_st, ha_end_st, h_last_st, hs_beg_st, hs_end_st;
  logic [15:0] va_beg_st, va_end_st, v_last_st, vs_beg_st, vs_end_st;
  logic cv_go = 1'b0;
  logic [15:0] cv_count = '0;
  logic hsync, vsync, de, line_stb, frame_stb, cv_done;
  logic [15:0] cv_state;

  int n_checks = 0;
  int n_errs   = 0;
  logic [4:0] exp_q[$];   // {hsync, vsync, de, line_stb, frame_stb}

  always #2.5 clk = ~clk;  // 200 MHz

  lfsr_raster_timing uut (.*);

  function automatic logic [15:0] ref_state(input int steps);
    logic [15:0] v = 16'hFFFF;
    for (int k = 0; k < steps; k++) v = {v[14:0], ^(v & 16'h8016)};
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        e = exp_q.pop_front();
        check("R4 hsync",     hsync,     e[4]);
        check("R5 vsync",     vsync,     e[3]);
        check("R6 de",        de,        e[2]);
        check("R2 line_stb",  line_stb,  e[1]);
        check("R3 frame_stb", frame_stb, e[0]);
      end
    end
  end

  // Driver: programs a mode from binary timings and pushes expected outputs.
  task automatic run_mode(input int hact, input int hss, input int hse, input int htot,
                          input int vact, input int vss, input int vse, input int vtot,
                          input int frames);
    int hb, hf, hl, hpw, vb, vf, vl, vpw, hk, vk;
    hb = htot - hss; hf = hb + hact; hl = htot - 1; hpw = hse - hss + 1;
    vb = vtot - vss; vf = vb + vact; vl = vtot;     vpw = vse - vss;
    @(negedge clk);
    rst_n = 1'b0;
    ha_beg_st = ref_state(hb); ha_end_st = ref_state(hf); h_last_st = ref_state(hl);
    hs_beg_st = ref_state(1);  hs_end_st = ref_state(hpw);
    va_beg_st = ref_state(vb); va_end_st = ref_state(vf); v_last_st = ref_state(vl);
    vs_beg_st = ref_state(0);  vs_end_st = ref_state(vpw);
    repeat (3) @(negedge clk);
    #1;
    check("R1 hsync in reset", hsync, 1'b0);
    check("R1 vsync in reset", vsync, 1'b1);
    check("R1 de in reset",    de,    1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    hk = 0; vk = 0;
    for (int n = 0; n < frames * (hl + 1) * (vl + 1); n++) begin
      logic [4:0] e;
      e[4] = (hk >= 1) && (hk < hpw);
      e[3] = (vk >= 0) && (vk < vpw);
      e[2] = (hk >= hb) && (hk < hf) && (vk >= vb) && (vk < vf);
      e[1] = (hk == hl);
      e[0] = (hk == hl) && (vk == vl);
      exp_q.push_back(e);
      if (hk == hl) begin
        hk = 0;
        vk = (vk == vl) ? 0 : vk + 1;
      end else hk++;
      @(negedge clk);
    end
    #2;
    check("R2 queue drained", exp_q.size(), 0);
  endtask

  task automatic run_conv(input int n);
    int waits;
    @(negedge clk);
    cv_count = n[15:0]; cv_go = 1'b1;
    @(negedge clk);
    cv_go = 1'b0;
    waits = 1;
    #1;
    if (n > 0) check("R8 done low while stepping", cv_done, 1'b0);
    while (!cv_done && waits < 70000) begin
      @(negedge clk); #1; waits++;
    end
    if (n == 0) begin
      check("R7 zero-count latency", waits, 1);
      check("R7 zero-count state",   cv_state, 16'hFFFF);
    end else begin
      check("R8 latency", waits, n + 1);
      check("R8 state",   cv_state, ref_state(n));
      repeat (3) @(negedge clk);
      #1;
      check("R8 result held", {cv_done, cv_state}, {1'b1, ref_state(n)});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    ha_beg_st = '0; ha_end_st = '0; h_last_st = '0; hs_beg_st = '0; hs_end_st = '0;
    va_beg_st = '0; va_end_st = '0; v_last_st = '0; vs_beg_st = '0; vs_end_st = '0;
    // Mode A: 10x6 active, 20 clocks per line, 13 lines
    run_mode(10, 12, 15, 20, 6, 8, 10, 12, 2);
    // Mode B: 16x8 active, 30 clocks per line, 17 lines
    run_mode(16, 20, 24, 30, 8, 11, 14, 16, 2);
    run_conv(0);
    run_conv(1);
    run_conv(7);
    run_conv(300);
    run_conv(0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule